// File: doc/BRIEF.md
# Memory-Mapped General-Purpose Pin Port

This block controls a bank of 32 general-purpose pins from a small register bus. Software writes an output latch and a direction mask; the pads receive the latch bits as drive values and the mask bits as per-pin output enables. Three write-only alias addresses change chosen latch bits in one bus write, with no read-modify-write. A write-one bit at the set alias forces the matching latch bit high. At the clear alias it forces the bit low, and at the invert alias it flips the bit. Bits written as zero leave the latch alone.

Pad input levels pass through a two-stage synchronizer before software can read them through a read-only input address. A per-pin digital-enable vector forces the read value of each disabled pin to zero. Each bus access takes one cycle and at most one happens per cycle. Read data is registered, so it appears one clock edge after the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: During and after reset, the output latch, the direction mask, `padOut`, `padOutEn` and `regRdData` are all zero.
- R2: A write to byte offset 0x00 replaces all 32 latch bits with `regWrData`. `padOut` shows the new value from the clock edge that takes the write.
- R3: A write to offset 0x04 sets to 1 every latch bit whose data bit is 1 and leaves every other bit unchanged.
- R4: A write to offset 0x08 clears to 0 every latch bit whose data bit is 1 and leaves every other bit unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose data bit is 1 and leaves every other bit unchanged.
- R6: A write to offset 0x14 loads the direction mask. `padOutEn[i]` equals mask bit i (1 = output, 0 = input) from the edge that takes the write.
- R7: A read of offset 0x10 returns, for each pin, the pin level delayed by two synchronizer stages, ANDed with `padDigEn`. A pin change made before edge e is returned by a read captured at edge e+2 or later. Reads captured at e and e+1 still return the old level.
- R8: Reads of offsets 0x00 and 0x14 return the latch and the direction mask. Reads of the aliases at 0x04, 0x08 and 0x0C return zero.
- R9: Writes to offset 0x10, to offsets at or above 0x18 and to offsets that are not multiples of 4 change neither the latch nor the mask. Reads of those unmapped offsets return zero.
- R10: `regRdData` is loaded at the edge where `regRdEn` is high and is zero after any edge where `regRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Byte offset of the access |
| regWrEn | input | 1 | Write strobe, one cycle |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe, one cycle |
| regRdData | output | 32 | Registered read data |
| padIn | input | 32 | Asynchronous pin input levels |
| padDigEn | input | 32 | Per-pin digital input enable |
| padOut | output | 32 | Pin drive values |
| padOutEn | output | 32 | Pin output enables |

## Verification
Writes to the latch, the aliases and the mask show on `padOut` and `padOutEn` after the single edge that takes the write, so the bench checks the pads at the falling edge that follows. Read data is due one edge after the read strobe, and the bench samples it at the next falling edge. Input levels need two more edges through the synchronizer. The bench changes a pin and then issues three back-to-back reads: it expects the old level from the first two and the new level from the third.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int OFS_OUT  = 'h00;
  localparam int OFS_SET  = 'h04;
  localparam int OFS_CLR  = 'h08;
  localparam int OFS_FLIP = 'h0C;
  localparam int OFS_IN   = 'h10;
  localparam int OFS_DIR  = 'h14;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_IN   = 2'd2,
    SEL_DIR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   loadOut;
    logic   setOut;
    logic   clrOut;
    logic   flipOut;
    logic   loadDir;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctrlStrb_t         strb
);
  logic hitOut, hitSet, hitClr, hitFlip, hitIn, hitDir;

  // Exact byte-offset match: misaligned and out-of-range offsets hit nothing.
  assign hitOut  = (regAddr == ADDR_W'(OFS_OUT));
  assign hitSet  = (regAddr == ADDR_W'(OFS_SET));
  assign hitClr  = (regAddr == ADDR_W'(OFS_CLR));
  assign hitFlip = (regAddr == ADDR_W'(OFS_FLIP));
  assign hitIn   = (regAddr == ADDR_W'(OFS_IN));
  assign hitDir  = (regAddr == ADDR_W'(OFS_DIR));

  always_comb begin
    strb          = '0;
    strb.loadOut  = regWrEn & hitOut;
    strb.setOut   = regWrEn & hitSet;
    strb.clrOut   = regWrEn & hitClr;
    strb.flipOut  = regWrEn & hitFlip;
    strb.loadDir  = regWrEn & hitDir;
    strb.rdStrobe = regRdEn;
    if (hitOut)      strb.rdSel = SEL_OUT;
    else if (hitIn)  strb.rdSel = SEL_IN;
    else if (hitDir) strb.rdSel = SEL_DIR;
    else             strb.rdSel = SEL_ZERO;
  end

  // R9
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadOut, strb.setOut, strb.clrOut, strb.flipOut, strb.loadDir}));

  // R9
  no_write_without_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(strb.loadOut | strb.setOut | strb.clrOut | strb.flipOut | strb.loadDir));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] padIn,
  input  logic [PIN_W-1:0] padDigEn,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padOutEn
);
  logic [PIN_W-1:0] outLatch, outNext;
  logic [PIN_W-1:0] dirMask;
  logic [PIN_W-1:0] pinSync;
  logic [PIN_W-1:0] rdMux;
  logic [PIN_W-1:0] rdReg;

  gpio_bank_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (pinSync)
  );

  always_comb begin
    outNext = outLatch;
    if (strb.loadOut)      outNext = wrData;
    else if (strb.setOut)  outNext = outLatch | wrData;
    else if (strb.clrOut)  outNext = outLatch & ~wrData;
    else if (strb.flipOut) outNext = outLatch ^ wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0;
      dirMask  <= '0;
    end else begin
      outLatch <= outNext;
      if (strb.loadDir) dirMask <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_OUT: rdMux = outLatch;
      SEL_IN:  rdMux = pinSync & padDigEn;
      SEL_DIR: rdMux = dirMask;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdReg <= '0;
    else if (strb.rdStrobe) rdReg <= rdMux;
    else                    rdReg <= '0;
  end

  assign rdData   = rdReg;
  assign padOut   = outLatch;
  assign padOutEn = dirMask;

  // R3
  set_bits_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOut |=> ((padOut & $past(wrData)) == $past(wrData)) &&
                    ((padOut & ~$past(wrData)) == ($past(padOut) & ~$past(wrData))));

  // R4
  clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOut |=> ((padOut & $past(wrData)) == '0) &&
                    ((padOut & ~$past(wrData)) == ($past(padOut) & ~$past(wrData))));

  // R5
  flip_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flipOut |=> (padOut == ($past(padOut) ^ $past(wrData))));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadOut | strb.setOut | strb.clrOut | strb.flipOut) |=> $stable(padOut));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDir |=> $stable(padOutEn));

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStrobe |=> (rdData == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [PIN_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [PIN_W-1:0]  regRdData,
  input  logic [PIN_W-1:0]  padIn,
  input  logic [PIN_W-1:0]  padDigEn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOutEn
);
  ctrlStrb_t strb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  gpio_bank_dp #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .padIn    (padIn),
    .padDigEn (padDigEn),
    .rdData   (regRdData),
    .padOut   (padOut),
    .padOutEn (padOutEn)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (padOut == '0) && (padOutEn == '0) && (regRdData == '0));
endmodule

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padDigEn = '0;
  logic [31:0] padOut;
  logic [31:0] padOutEn;

  int checks = 0;
  int fails  = 0;
  logic [31:0] outM = '0;
  logic [31:0] dirM = '0;

  always #2 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .padIn(padIn), .padDigEn(padDigEn), .padOut(padOut), .padOutEn(padOutEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextOut(input logic [4:0] a, input logic [31:0] d,
                                          input logic [31:0] cur);
    case (a)
      5'h00:   return d;
      5'h04:   return cur | d;
      5'h08:   return cur & ~d;
      5'h0C:   return cur ^ d;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] readModel(input logic [4:0] a);
    case (a)
      5'h00:   return outM;
      5'h14:   return dirM;
      default: return '0;
    endcase
  endfunction

  // Starts and ends at a falling edge.
  task automatic doWrite(input logic [4:0] a, input logic [31:0] d, input string tag);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    outM = nextOut(a, d, outM);
    if (a == 5'h14) dirM = d;
    check({tag, " padOut"}, padOut, outM);
    check({tag, " padOutEn"}, padOutEn, dirM);
    check({tag, " R10 idle read"}, regRdData, 32'h0);
  endtask

  task automatic doRead(input logic [4:0] a, input logic [31:0] exp, input string tag);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regRdEn = 1'b0;
    check(tag, regRdData, exp);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 padOut", padOut, 32'h0);
    check("R1 padOutEn", padOutEn, 32'h0);
    check("R1 rdData", regRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    doRead(5'h00, 32'h0, "R1 latch read");
    doRead(5'h14, 32'h0, "R1 dir read");

    // Directed
    doWrite(5'h00, 32'hA5A5_0F0F, "R2 load");
    doRead(5'h00, 32'hA5A5_0F0F, "R8 latch read");
    doWrite(5'h04, 32'h0000_00F0, "R3 set");
    doWrite(5'h04, 32'h0, "R3 set zero");
    doWrite(5'h08, 32'hA000_000F, "R4 clear");
    doWrite(5'h0C, 32'hFFFF_0000, "R5 flip");
    doWrite(5'h0C, 32'h0, "R5 flip zero");
    doWrite(5'h14, 32'hFFFF_00FF, "R6 dir");
    doRead(5'h14, 32'hFFFF_00FF, "R8 dir read");
    doRead(5'h04, 32'h0, "R8 set alias read");
    doRead(5'h08, 32'h0, "R8 clear alias read");
    doRead(5'h0C, 32'h0, "R8 flip alias read");
    doWrite(5'h10, 32'hDEAD_BEEF, "R9 input write");
    doWrite(5'h18, 32'hDEAD_BEEF, "R9 0x18 write");
    doWrite(5'h1C, 32'hDEAD_BEEF, "R9 0x1C write");
    doWrite(5'h01, 32'hDEAD_BEEF, "R9 misaligned write");
    doRead(5'h18, 32'h0, "R9 unmapped read");
    doRead(5'h02, 32'h0, "R9 misaligned read");
    doRead(5'h00, outM, "R9 latch intact");

    // R7 synchronizer latency and masking
    padDigEn = 32'hFFFF_FFFF;
    padIn = 32'h0;
    repeat (3) @(negedge clk);
    padIn = 32'h1234_5678;
    doRead(5'h10, 32'h0, "R7 edge e old");
    doRead(5'h10, 32'h0, "R7 edge e+1 old");
    doRead(5'h10, 32'h1234_5678, "R7 edge e+2 new");
    padDigEn = 32'h0000_FFFF;
    doRead(5'h10, 32'h0000_5678, "R7 masked");
    padDigEn = 32'h0;
    doRead(5'h10, 32'h0, "R7 all disabled");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [4:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = $urandom;
      case (op)
        0: a = 5'h00;
        1: a = 5'h04;
        2: a = 5'h08;
        3: a = 5'h0C;
        4: a = 5'h14;
        5: a = 5'h10;
        default: a = 5'($urandom_range(0, 31));
      endcase
      if (op < 6 || (op & 1) == 0) begin
        doWrite(a, d, "R2-R6 random write (R3 R4 R5 R9)");
      end else if (a == 5'h10) begin
        padDigEn = $urandom;
        padIn = $urandom;
        repeat (2) @(negedge clk);
        doRead(a, padIn & padDigEn, "R7 random input");
      end else begin
        doRead(a, readModel(a), "R8 random read");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule